// File: doc/BRIEF.md
# Lane Exchange and Vote Unit

This block sits beside a group of 32 lanes that issue the same operation in the same cycle. It lets the lanes trade register words with each other without a trip through memory, and it can reduce one predicate bit per lane into a shared mask or a single yes/no answer. The caller presents one request per cycle. A request carries an opcode, one data word, one source index and one predicate per lane, and a mask of the lanes that are currently active.

Four operations are supported. A shuffle hands each active lane the word held by the lane it names. A ballot packs the predicates of the active lanes into a mask and gives that mask to every active lane. The any and all votes collapse that mask into one flag. Lanes that are switched off by divergence take no part: they add nothing to the mask, and their result words keep what they held before. Results are registered, so each request is answered on the following clock edge, and a new request may follow on every cycle.

Top module: `warp_xchg_unit`

## Requirements
- R1: After reset `rsp_valid`, `rsp_flag`, `rsp_mask` and every `rsp_data` word are zero.
- R2: For opcode 0 (shuffle), each active lane i gets in `rsp_data[32*i+31:32*i]` the data word of source lane `req_idx[8*i+7:8*i] mod 32`, `rsp_flag` is 0, and `rsp_mask` is `req_pred & req_active`.
- R3: Source indices wrap modulo 32: an index of 255 selects lane 31 and an index of 33 selects lane 1.
- R4: A shuffle whose source lane is inactive returns the requesting lane's own input word.
- R5: For opcode 1 (ballot), `rsp_mask` bit i equals `req_pred[i] & req_active[i]`, every active lane's word is that mask, and `rsp_flag` is 0.
- R6: For opcode 2 (any), `rsp_flag` is 1 exactly when `req_pred & req_active` is nonzero, and every active lane's word is the flag zero-extended to 32 bits.
- R7: For opcode 3 (all), `rsp_flag` is 1 exactly when `req_pred & req_active` equals `req_active` (so 1 when no lane is active), and every active lane's word is the flag zero-extended.
- R8: The `rsp_data` word of a lane that is inactive in an accepted request keeps its previous value.
- R9: A request with `req_valid` high is answered one cycle later with `rsp_valid` high, and requests on consecutive cycles are each answered on consecutive cycles.
- R10: In a cycle with `req_valid` low, `rsp_valid` falls to 0 on the next edge and `rsp_data`, `rsp_mask` and `rsp_flag` keep their values whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 shuffle, 1 ballot, 2 any, 3 all |
| req_data | input | 1024 | Per-lane data words, lane i at bits 32*i+31:32*i |
| req_idx | input | 256 | Per-lane source index, lane i at bits 8*i+7:8*i |
| req_pred | input | 32 | Per-lane predicate bit |
| req_active | input | 32 | Lanes taking part in the request |
| rsp_valid | output | 1 | Result registered from a request |
| rsp_data | output | 1024 | Per-lane result words |
| rsp_mask | output | 32 | Predicates of active lanes |
| rsp_flag | output | 1 | Any/all vote result |

## Verification
The bench rotates words left by one so lane 0 must reach across to lane 31, and feeds indices above 31 to catch a design that does not fold them back; a missed wrap would return a wrong lane or out-of-range data. Partial active masks check that a design reading an inactive source does not forward that lane's stale word and that an inactive lane's output is not overwritten. The all vote with no active lanes must answer 1, and the any vote with predicates set only on inactive lanes must answer 0; a design that forgot to mask the predicates would flip both. Idle cycles with garbage on the inputs expose a design that loads results without a request.

// File: rtl/warp_xchg_pkg.sv
package warp_xchg_pkg;

    typedef enum logic [1:0] {
        OP_SHFL   = 2'd0,
        OP_BALLOT = 2'd1,
        OP_ANY    = 2'd2,
        OP_ALL    = 2'd3
    } xchg_op_e;

endpackage

// File: rtl/warp_xchg_xbar.sv
module warp_xchg_xbar #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int IW    = 8
) (
    input  logic [LANES*DW-1:0] data_i,
    input  logic [LANES*IW-1:0] idx_i,
    input  logic [LANES-1:0]    active_i,
    output logic [LANES*DW-1:0] shfl_o
);
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IW-1:0]   raw_idx;
        logic [SELW-1:0] src_sel;
        logic [DW-1:0]   src_word;
        logic [DW-1:0]   own_word;

        assign raw_idx  = idx_i[g*IW +: IW];
        assign src_sel  = SELW'(raw_idx % LANES);
        assign own_word = data_i[g*DW +: DW];

        always_comb begin
            src_word = own_word;
            for (int s = 0; s < LANES; s++) begin
                if (src_sel == SELW'(s) && active_i[s]) begin
                    src_word = data_i[s*DW +: DW];
                end
            end
        end

        assign shfl_o[g*DW +: DW] = src_word;
    end

endmodule

// File: rtl/warp_xchg_vote.sv
module warp_xchg_vote #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] pred_i,
    input  logic [LANES-1:0] active_i,
    output logic [LANES-1:0] mask_o,
    output logic             any_o,
    output logic             all_o
);
    assign mask_o = pred_i & active_i;
    assign any_o  = |mask_o;
    assign all_o  = (mask_o == active_i);

endmodule

// File: rtl/warp_xchg_unit.sv
module warp_xchg_unit
    import warp_xchg_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int IW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [LANES*DW-1:0] req_data,
    input  logic [LANES*IW-1:0] req_idx,
    input  logic [LANES-1:0]    req_pred,
    input  logic [LANES-1:0]    req_active,
    output logic                rsp_valid,
    output logic [LANES*DW-1:0] rsp_data,
    output logic [LANES-1:0]    rsp_mask,
    output logic                rsp_flag
);
    typedef struct packed {
        logic                valid;
        logic [LANES*DW-1:0] data;
        logic [LANES-1:0]    mask;
        logic                flag;
    } state_t;

    state_t st_d, st_q;

    xchg_op_e            op_w;
    logic [LANES*DW-1:0] shfl_w;
    logic [LANES-1:0]    vmask_w;
    logic                any_w, all_w;
    logic                flag_w;

    assign op_w = xchg_op_e'(req_op);

    warp_xchg_xbar #(.LANES(LANES), .DW(DW), .IW(IW)) xbar_i (
        .data_i   (req_data),
        .idx_i    (req_idx),
        .active_i (req_active),
        .shfl_o   (shfl_w)
    );

    warp_xchg_vote #(.LANES(LANES)) vote_i (
        .pred_i   (req_pred),
        .active_i (req_active),
        .mask_o   (vmask_w),
        .any_o    (any_w),
        .all_o    (all_w)
    );

    always_comb begin
        case (op_w)
            OP_ANY:  flag_w = any_w;
            OP_ALL:  flag_w = all_w;
            default: flag_w = 1'b0;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        if (req_valid) begin
            st_d.mask = vmask_w;
            st_d.flag = flag_w;
            for (int i = 0; i < LANES; i++) begin
                if (req_active[i]) begin
                    case (op_w)
                        OP_SHFL:   st_d.data[i*DW +: DW] = shfl_w[i*DW +: DW];
                        OP_BALLOT: st_d.data[i*DW +: DW] = DW'(vmask_w);
                        default:   st_d.data[i*DW +: DW] = DW'(flag_w);
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_data  = st_q.data;
    assign rsp_mask  = st_q.mask;
    assign rsp_flag  = st_q.flag;

    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_data) && $stable(rsp_mask) && $stable(rsp_flag)));

    p_mask_inactive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((rsp_mask & ~$past(req_active)) == '0));

    p_any_vote_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2) |=> (rsp_flag == (rsp_mask != '0)));

    p_all_vote_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (rsp_flag == (rsp_mask == $past(req_active))));

    for (genvar g = 0; g < LANES; g++) begin : g_hold_chk
        p_lane_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_active[g]) |=> $stable(rsp_data[g*DW +: DW]));
    end

endmodule

// File: tb/warp_xchg_unit_tb_top.sv
module warp_xchg_unit_tb_top;
    localparam int L  = 32;
    localparam int DW = 32;
    localparam int IW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_op = 2'd0;
    logic [L*DW-1:0] req_data = '0;
    logic [L*IW-1:0] req_idx = '0;
    logic [L-1:0]    req_pred = '0;
    logic [L-1:0]    req_active = '0;
    logic            rsp_valid;
    logic [L*DW-1:0] rsp_data;
    logic [L-1:0]    rsp_mask;
    logic            rsp_flag;

    always #2 clk = ~clk;

    warp_xchg_unit #(.LANES(L), .DW(DW), .IW(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .req_idx(req_idx), .req_pred(req_pred),
        .req_active(req_active), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_mask(rsp_mask), .rsp_flag(rsp_flag)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [L*DW-1:0] m_data = '0;
    logic [L-1:0]    m_mask = '0;
    logic            m_flag = 1'b0;
    logic            m_valid = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [L*DW-1:0] act, input logic [L*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rsp_valid (R9)", L*DW'(rsp_valid), L*DW'(m_valid));
        check(tag, "rsp_mask", L*DW'(rsp_mask), L*DW'(m_mask));
        check(tag, "rsp_flag", L*DW'(rsp_flag), L*DW'(m_flag));
        check(tag, "rsp_data", rsp_data, m_data);
    endtask

    // behavioural reference: update on the edge that takes the request
    task automatic model_step(input logic v, input int op, input logic [L*DW-1:0] d,
                              input logic [L*IW-1:0] ix, input logic [L-1:0] p,
                              input logic [L-1:0] a);
        logic [L*DW-1:0] nd;
        logic [L-1:0]    msk;
        logic            f;
        m_valid = v;
        if (!v) return;
        msk = p & a;
        f = 1'b0;
        if (op == 2) f = (msk != 0);
        if (op == 3) f = (msk == a);
        nd = m_data;
        for (int i = 0; i < L; i++) begin
            if (a[i]) begin
                int s;
                s = int'(ix[i*IW +: IW]) % L;
                if (op == 0) nd[i*DW +: DW] = a[s] ? d[s*DW +: DW] : d[i*DW +: DW];
                else if (op == 1) nd[i*DW +: DW] = DW'(msk);
                else nd[i*DW +: DW] = DW'(f);
            end
        end
        m_data = nd;
        m_mask = msk;
        m_flag = f;
    endtask

    task automatic cycle(input string tag, input logic v, input int op,
                         input logic [L*DW-1:0] d, input logic [L*IW-1:0] ix,
                         input logic [L-1:0] p, input logic [L-1:0] a);
        req_valid  = v;
        req_op     = 2'(op);
        req_data   = d;
        req_idx    = ix;
        req_pred   = p;
        req_active = a;
        @(posedge clk);
        model_step(v, op, d, ix, p, a);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [L*DW-1:0] mk_data(input int seed);
        logic [L*DW-1:0] r;
        for (int i = 0; i < L; i++) r[i*DW +: DW] = 32'hA000_0000 + 32'(seed * 256 + i * 3 + 1);
        return r;
    endfunction

    function automatic logic [L*IW-1:0] mk_idx(input int mul, input int add);
        logic [L*IW-1:0] r;
        for (int i = 0; i < L; i++) r[i*IW +: IW] = 8'((i * mul + add) & 255);
        return r;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset state");

        // R2 R3: rotate left by one, lane 0 index 255 wraps to lane 31
        cycle("R2 R3 rotate", 1, 0, mk_data(1), mk_idx(1, 255), 32'h0F0F_1234, '1);
        // R3: indices above 31 fold back, back-to-back with previous (R9)
        cycle("R3 R9 wide index", 1, 0, mk_data(2), mk_idx(7, 33), 32'h0, '1);
        // R4 R8: odd lanes inactive, rotate reads inactive sources
        cycle("R4 R8 inactive source", 1, 0, mk_data(3), mk_idx(1, 1), 32'hFFFF_FFFF, 32'h5555_5555);
        // R2: broadcast lane 5 to all
        cycle("R2 broadcast", 1, 0, mk_data(4), mk_idx(0, 5), 32'h0, '1);
        // R5: ballot all active
        cycle("R5 ballot full", 1, 1, mk_data(5), mk_idx(3, 9), 32'hDEAD_BEEF, '1);
        // R5 R8: ballot partial
        cycle("R5 R8 ballot partial", 1, 1, mk_data(6), mk_idx(3, 9), 32'hFFFF_00FF, 32'h00FF_FF00);
        // R6: predicates only on inactive lanes -> 0
        cycle("R6 any masked", 1, 2, mk_data(7), '0, 32'hF000_000F, 32'h0FFF_FFF0);
        cycle("R6 any true", 1, 2, mk_data(8), '0, 32'h0000_0100, 32'h0000_FF00);
        // R7
        cycle("R7 all true", 1, 3, mk_data(9), '0, 32'hFFFF_0F0F, 32'h0000_0F0F);
        cycle("R7 all false", 1, 3, mk_data(10), '0, 32'hFFFF_0E0F, 32'hFFFF_0F0F);
        cycle("R7 R8 all none active", 1, 3, mk_data(11), '0, 32'h0, 32'h0);
        // R10: idle with garbage inputs
        cycle("R10 idle", 0, 1, mk_data(12), mk_idx(5, 2), 32'h1234_5678, '1);
        cycle("R10 idle again", 0, 0, mk_data(13), mk_idx(9, 4), 32'h8765_4321, 32'hAAAA_AAAA);
        // R9: request after idle answered next cycle
        cycle("R9 R2 after idle", 1, 0, mk_data(14), mk_idx(31, 0), 32'h3, 32'hFFFF_0000);
        cycle("R10 final idle", 0, 3, '0, '0, '0, '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule